// File: doc/BRIEF.md
# Descriptor-Program DMA Sequencer

This block runs a small instruction program stored in a descriptor memory and uses it to launch DMA transfers one at a time. One memory holds three kinds of word: instructions, constant words (such as pointers to entries), and transfer entries. Each entry is three consecutive words: host address low, host address high, and a transfer-control word. The program loads an entry-offset register indirectly from a constant word. It then reads the address pair and the control word at that offset plus a small displacement. It hands each enabled transfer to a DMA engine through a request/done handshake and waits for it to finish. Event instructions can pulse an interrupt and stop the engine.

The host writes the memory through a dedicated write port and starts the program with a one-cycle go pulse at a chosen start word. It can hold the engine at an instruction boundary with a pause level, rewrite memory while held, and then release it. The program counter and the entry-offset register are always visible on output ports for debug.

Top module: `dsq_top`

## Requirements
- R1: After reset, busy_o, irq_o and xfer_req are 0, and pc_o and entry_o are 0.
- R2: The opcode is instruction bits [31:28]. Opcode 0 is a no-operation. Opcode 1 loads the entry-offset register (seen on entry_o) from the memory word whose address is in instruction bits [ADDR_W-1:0].
- R3: Opcode 2 takes a displacement from bits [7:0]. It sets the host address low half from word (entry+disp) and the high half from word (entry+disp+1).
- R4: Opcode 3 reads the control word at (entry+disp). The control word layout is count [15:0], stream [19:16], direction [20], enable [24] and flag [25]. When enable is 1, xfer_req rises with xfer_addr and xfer_ctl set to the loaded values. These outputs and pc_o stay unchanged until xfer_done is seen, and only then is the next instruction fetched.
- R5: A transfer-control word with enable 0 raises no request, and execution continues with the next instruction.
- R6: Opcode 4 is an event. When bit 0 is 1, irq_o pulses for exactly one cycle. When bit 1 is 1, the engine stops: busy_o goes to 0 and pc_o holds the event's address plus one.
- R7: Opcodes 5 to 15 behave as no-operations. They issue no transfer and no interrupt, and they leave entry_o unchanged.
- R8: A go pulse while idle starts execution at start_pc. A go pulse while busy is ignored.
- R9: While pause is 1, no new instruction is fetched and pc_o holds its value. Memory written during the pause is what the program uses after release.
- R10: The program counter wraps from the last memory word to word 0.
- R11: Entry-plus-displacement addresses wrap modulo the memory depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host memory write strobe |
| host_waddr | input | ADDR_W | Host write word address |
| host_wdata | input | 32 | Host write data |
| go | input | 1 | Start pulse, used only while idle |
| start_pc | input | ADDR_W | First instruction address |
| pause | input | 1 | Hold at the next instruction boundary |
| pc_o | output | ADDR_W | Program counter |
| entry_o | output | ADDR_W | Entry-offset register |
| busy_o | output | 1 | Program running or held |
| irq_o | output | 1 | One-cycle event interrupt |
| xfer_req | output | 1 | Transfer request, held until done |
| xfer_done | input | 1 | Transfer completion from the DMA engine |
| xfer_addr | output | 64 | Host address of the transfer |
| xfer_ctl | output | 32 | Transfer-control word of the transfer |

## Verification
The hardest state to reach is a program held mid-run at an instruction boundary. In that state the host must rewrite an entry, send a stray go that must be ignored, and then release the engine so that the rewritten value is the one used. The bench reaches it by raising pause before go, which leaves the engine holding at its start word. It then checks the held program counter, does the rewrite and releases pause. The same program starts near the top of memory, so that program-counter wrap and displacement wrap are exercised in a single run.

// File: rtl/dsq_pkg.sv
`timescale 1ns/1ps
package dsq_pkg;
  localparam int OPC_W        = 4;
  localparam int DISP_W       = 8;
  localparam int CTL_EN_BIT   = 24;
  localparam int EV_IRQ_BIT   = 0;
  localparam int EV_HALT_BIT  = 1;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'd0,
    OP_LDENT = 4'd1,
    OP_LDADR = 4'd2,
    OP_LDCTL = 4'd3,
    OP_EVENT = 4'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_ENT, ST_ALO, ST_AHI, ST_CTL, ST_WAIT
  } st_e;
endpackage

// File: rtl/dsq_ram.sv
`timescale 1ns/1ps
module dsq_ram #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/dsq_decode.sv
`timescale 1ns/1ps
module dsq_decode
  import dsq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [31:0]       word,
  output op_e               op,
  output logic [ADDR_W-1:0] abs_addr,
  output logic [DISP_W-1:0] disp,
  output logic              ev_irq,
  output logic              ev_halt
);
  logic unused_mid;
  assign unused_mid = ^word[27:DISP_W];

  always_comb begin
    unique case (word[31:28])
      4'd1:    op = OP_LDENT;
      4'd2:    op = OP_LDADR;
      4'd3:    op = OP_LDCTL;
      4'd4:    op = OP_EVENT;
      default: op = OP_NOP;
    endcase
  end

  assign abs_addr = word[ADDR_W-1:0];
  assign disp     = word[DISP_W-1:0];
  assign ev_irq   = word[EV_IRQ_BIT];
  assign ev_halt  = word[EV_HALT_BIT];
endmodule

// File: rtl/dsq_ctrl.sv
`timescale 1ns/1ps
module dsq_ctrl
  import dsq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic              pause,
  input  logic [31:0]       rd_data,
  input  op_e               dec_op,
  input  logic [ADDR_W-1:0] dec_abs,
  input  logic [DISP_W-1:0] dec_disp,
  input  logic              dec_irq,
  input  logic              dec_halt,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] ent_q,
  output logic              busy,
  output logic              irq_q,
  output logic              xfer_req,
  output logic [63:0]       xfer_addr,
  output logic [31:0]       xfer_ctl
);
  st_e               st_q, st_n;
  logic [ADDR_W-1:0] pc_n, ent_n;
  logic [DISP_W-1:0] disp_q, disp_n;
  logic [31:0]       lo_q, lo_n, hi_q, hi_n, ctl_q, ctl_n;
  logic              irq_n;

  function automatic logic [ADDR_W-1:0] f_ea(input logic [ADDR_W-1:0] base,
                                             input logic [DISP_W-1:0] d);
    return base + ADDR_W'(d);
  endfunction

  always_comb begin
    st_n    = st_q;
    pc_n    = pc_q;
    ent_n   = ent_q;
    disp_n  = disp_q;
    lo_n    = lo_q;
    hi_n    = hi_q;
    ctl_n   = ctl_q;
    irq_n   = 1'b0;
    rd_addr = pc_q;
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          st_n = ST_FETCH;
          pc_n = start_pc;
        end
      end
      ST_FETCH: begin
        if (!pause) st_n = ST_EXEC;
      end
      ST_EXEC: begin
        pc_n   = pc_q + ADDR_W'(1);
        disp_n = dec_disp;
        unique case (dec_op)
          OP_LDENT: begin
            rd_addr = dec_abs;
            st_n    = ST_ENT;
          end
          OP_LDADR: begin
            rd_addr = f_ea(ent_q, dec_disp);
            st_n    = ST_ALO;
          end
          OP_LDCTL: begin
            rd_addr = f_ea(ent_q, dec_disp);
            st_n    = ST_CTL;
          end
          OP_EVENT: begin
            irq_n = dec_irq;
            st_n  = dec_halt ? ST_IDLE : ST_FETCH;
          end
          default: st_n = ST_FETCH;
        endcase
      end
      ST_ENT: begin
        ent_n = rd_data[ADDR_W-1:0];
        st_n  = ST_FETCH;
      end
      ST_ALO: begin
        lo_n    = rd_data;
        rd_addr = f_ea(ent_q, disp_q) + ADDR_W'(1);
        st_n    = ST_AHI;
      end
      ST_AHI: begin
        hi_n = rd_data;
        st_n = ST_FETCH;
      end
      ST_CTL: begin
        ctl_n = rd_data;
        st_n  = rd_data[CTL_EN_BIT] ? ST_WAIT : ST_FETCH;
      end
      ST_WAIT: begin
        if (xfer_done) st_n = ST_FETCH;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pc_q   <= '0;
      ent_q  <= '0;
      disp_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      ctl_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pc_q   <= pc_n;
      ent_q  <= ent_n;
      disp_q <= disp_n;
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      ctl_q  <= ctl_n;
      irq_q  <= irq_n;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign xfer_req  = (st_q == ST_WAIT);
  assign xfer_addr = {hi_q, lo_q};
  assign xfer_ctl  = ctl_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_ctl))); // R4
  AST_PC_FROZEN_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> $stable(pc_q)); // R4
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R6
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !xfer_req); // R6
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH && pause) |=> (st_q == ST_FETCH && $stable(pc_q))); // R9
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go && st_q == ST_FETCH && pause) |=> $stable(pc_q)); // R8
endmodule

// File: rtl/dsq_top.sv
`timescale 1ns/1ps
module dsq_top
  import dsq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [31:0]       host_wdata,
  input  logic              go,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic              pause,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] entry_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              xfer_req,
  input  logic              xfer_done,
  output logic [63:0]       xfer_addr,
  output logic [31:0]       xfer_ctl
);
  logic [ADDR_W-1:0] rd_addr;
  logic [31:0]       rd_data;
  op_e               dec_op;
  logic [ADDR_W-1:0] dec_abs;
  logic [DISP_W-1:0] dec_disp;
  logic              dec_irq, dec_halt;

  dsq_ram #(.ADDR_W(ADDR_W)) i_ram (
    .clk     (clk),
    .wr_en   (host_we),
    .wr_addr (host_waddr),
    .wr_data (host_wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  dsq_decode #(.ADDR_W(ADDR_W)) i_dec (
    .word     (rd_data),
    .op       (dec_op),
    .abs_addr (dec_abs),
    .disp     (dec_disp),
    .ev_irq   (dec_irq),
    .ev_halt  (dec_halt)
  );

  dsq_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .start_pc  (start_pc),
    .pause     (pause),
    .rd_data   (rd_data),
    .dec_op    (dec_op),
    .dec_abs   (dec_abs),
    .dec_disp  (dec_disp),
    .dec_irq   (dec_irq),
    .dec_halt  (dec_halt),
    .xfer_done (xfer_done),
    .rd_addr   (rd_addr),
    .pc_q      (pc_o),
    .ent_q     (entry_o),
    .busy      (busy_o),
    .irq_q     (irq_o),
    .xfer_req  (xfer_req),
    .xfer_addr (xfer_addr),
    .xfer_ctl  (xfer_ctl)
  );
endmodule

// File: tb/test_dsq_top.sv
`timescale 1ns/1ps
module test_dsq_top;
  localparam int AW = 6;
  localparam int N  = 6;

  logic          clk, rst_n, host_we, go, pause, xfer_done;
  logic [AW-1:0] host_waddr, start_pc;
  logic [31:0]   host_wdata;
  logic [AW-1:0] pc_o, entry_o;
  logic          busy_o, irq_o, xfer_req;
  logic [63:0]   xfer_addr;
  logic [31:0]   xfer_ctl;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  int log_cnt = 0;
  logic [63:0] log_addr [64];
  logic [31:0] log_ctl  [64];

  dsq_top #(.ADDR_W(AW)) i_dsq_top (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .go(go), .start_pc(start_pc), .pause(pause),
    .pc_o(pc_o), .entry_o(entry_o), .busy_o(busy_o), .irq_o(irq_o),
    .xfer_req(xfer_req), .xfer_done(xfer_done), .xfer_addr(xfer_addr),
    .xfer_ctl(xfer_ctl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w_ent(input int a);  return {4'h1, 28'(a)}; endfunction
  function automatic logic [31:0] w_adr(input int d);  return {4'h2, 20'h0, 8'(d)}; endfunction
  function automatic logic [31:0] w_ctl(input int d);  return {4'h3, 20'h0, 8'(d)}; endfunction
  function automatic logic [31:0] w_ev(input bit irq, input bit hlt);
    return {4'h4, 26'h0, hlt, irq};
  endfunction
  function automatic logic [31:0] mkctl(input int cnt, input int strm, input bit dir,
                                        input bit en, input bit flag);
    return {6'h0, flag, en, 3'h0, dir, 4'(strm), 16'(cnt)};
  endfunction
  function automatic logic [31:0] lo_of(input int k); return 32'h1000_0000 + 32'(k) * 32'h0101_0011; endfunction
  function automatic logic [31:0] hi_of(input int k); return 32'hA000_0000 | 32'(k); endfunction
  function automatic logic [31:0] ctl_of(input int k, input bit en);
    return mkctl(16'h40 + 8*k, k, k[0], en, k[1]);
  endfunction

  always @(negedge clk) if (irq_o === 1'b1) irq_cnt++;

  // DMA engine model: logs each request, holds done off for a varying time
  initial begin
    logic [AW-1:0] pc_hold;
    xfer_done = 1'b0;
    forever begin
      @(negedge clk);
      if (xfer_req === 1'b1) begin
        log_addr[log_cnt] = xfer_addr;
        log_ctl[log_cnt]  = xfer_ctl;
        pc_hold = pc_o;
        repeat ((log_cnt % 4) + 1) @(negedge clk);
        chk("R4 pc frozen while transfer pending", 64'(pc_o), 64'(pc_hold));
        chk("R4 request held until done", 64'(xfer_req), 64'd1);
        log_cnt++;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic pulse_go(input int s);
    @(negedge clk);
    go = 1'b1; start_pc = AW'(s);
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (busy_o !== 1'b0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk("R6 program reaches halt", 64'(t < 3000), 64'd1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #4ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int l0, i0;
    rst_n = 1'b0; host_we = 1'b0; host_waddr = '0; host_wdata = '0;
    go = 1'b0; start_pc = '0; pause = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", 64'(busy_o), 0);
    chk("R1 pc at reset", 64'(pc_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 entry after reset", 64'(entry_o), 0);
    chk("R1 req/irq after reset", {62'd0, xfer_req, irq_o}, 0);

    // R2 R3 R4: sweep of N entries reached through a pointer table
    for (int k = 0; k < N; k++) begin
      wr(3*k,   w_ent(20 + k));
      wr(3*k+1, w_adr(0));
      wr(3*k+2, w_ctl(2));
      wr(20 + k, 32'(28 + 5*k));
      wr(28 + 5*k,     lo_of(k));
      wr(28 + 5*k + 1, hi_of(k));
      wr(28 + 5*k + 2, ctl_of(k, 1'b1));
    end
    wr(3*N, w_ev(1'b1, 1'b1));
    l0 = log_cnt; i0 = irq_cnt;
    pulse_go(0);
    wait_idle();
    chk("R4 transfer count", 64'(log_cnt - l0), N);
    for (int k = 0; k < N; k++) begin
      chk("R3 host address of entry", log_addr[l0+k], {hi_of(k), lo_of(k)});
      chk("R4 control word of entry", 64'(log_ctl[l0+k]), 64'(ctl_of(k, 1'b1)));
    end
    chk("R6 halt pc", 64'(pc_o), 3*N + 1);
    chk("R6 one irq pulse", 64'(irq_cnt - i0), 1);
    chk("R2 entry register", 64'(entry_o), 28 + 5*(N-1));

    // R5: odd entries disabled
    for (int k = 1; k < N; k += 2) wr(28 + 5*k + 2, ctl_of(k, 1'b0));
    l0 = log_cnt;
    pulse_go(0);
    wait_idle();
    chk("R5 only enabled entries issue", 64'(log_cnt - l0), (N+1)/2);
    for (int j = 0; j < (N+1)/2; j++)
      chk("R5 enabled entry address", log_addr[l0+j], {hi_of(2*j), lo_of(2*j)});

    // R7: undefined opcodes
    for (int op = 5; op < 16; op++) wr(op - 5, {4'(op), 28'(20)});
    wr(11, w_ev(1'b0, 1'b1));
    l0 = log_cnt; i0 = irq_cnt;
    pulse_go(0);
    wait_idle();
    chk("R7 no transfer", 64'(log_cnt - l0), 0);
    chk("R7 no irq", 64'(irq_cnt - i0), 0);
    chk("R7 entry unchanged", 64'(entry_o), 28 + 5*(N-1));
    chk("R7 pc after run", 64'(pc_o), 12);

    // R6 R8: events without halt, nonzero start
    wr(56, w_ev(1'b1, 1'b0));
    wr(57, w_ev(1'b1, 1'b0));
    wr(58, w_ev(1'b0, 1'b1));
    i0 = irq_cnt;
    pulse_go(56);
    wait_idle();
    chk("R6 irq pulses counted", 64'(irq_cnt - i0), 2);
    chk("R8 start address honoured", 64'(pc_o), 59);

    // R10 R11: program wrapping past the top, displaced entry wrapping
    wr(62, w_ent(59));
    wr(63, w_adr(20));
    wr(0, w_ctl(22));
    wr(1, w_ev(1'b1, 1'b1));
    wr(59, 32'd50);
    wr(6, 32'h1357_9BDF);
    wr(7, 32'h0000_00C4);
    wr(8, mkctl(16'h0200, 3, 1'b1, 1'b1, 1'b0));
    l0 = log_cnt;
    pulse_go(62);
    wait_idle();
    chk("R10 wrapped program transfer", 64'(log_cnt - l0), 1);
    chk("R11 wrapped entry address", log_addr[l0], 64'h0000_00C4_1357_9BDF);
    chk("R11 wrapped control word", 64'(log_ctl[l0]), 64'(mkctl(16'h0200, 3, 1'b1, 1'b1, 1'b0)));
    chk("R10 pc after wrap", 64'(pc_o), 2);
    chk("R2 entry after wrap run", 64'(entry_o), 50);

    // R9 R8: hold, stray go, rewrite, release
    pause = 1'b1;
    l0 = log_cnt;
    pulse_go(62);
    repeat (10) @(negedge clk);
    chk("R9 held busy", 64'(busy_o), 1);
    chk("R9 held pc", 64'(pc_o), 62);
    chk("R9 no transfer while held", 64'(log_cnt - l0), 0);
    pulse_go(0);
    repeat (3) @(negedge clk);
    chk("R8 go while busy ignored", 64'(pc_o), 62);
    wr(6, 32'h2468_ACE0);
    pause = 1'b0;
    wait_idle();
    chk("R9 rewritten entry used", log_addr[l0], 64'h0000_00C4_2468_ACE0);
    chk("R9 pc after release", 64'(pc_o), 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule